// File: doc/BRIEF.md
# Hermitian Covariance Matrix Estimator

This block forms the sample covariance of a complex snapshot matrix with up to eight channels (rows) and up to 256 snapshots (columns). A pulse on `start` latches the channel count, the snapshot count and a normalisation shift. The block then takes the samples as one linear stream in row-major order, one sample per accepted write. Each sample is placed in one of sixteen operand banks. The bank is chosen by the snapshot index modulo sixteen. The address within the bank packs the higher snapshot bits with the channel index.

When the last sample has arrived, the block computes only the entries on and below the diagonal. Each one is a conjugate dot product across all snapshots, at one snapshot per cycle. The results are stored in column order, and each can be scaled by an arithmetic right shift, which divides by K when K is a power of two. The read port serves any entry combinationally. An entry above the diagonal comes from its mirror below the diagonal with the imaginary part negated, so it costs no computation.

Top module: `covar_est`

## Requirements
- R1: For row a ≥ column b, the entry read at (a,b) equals the sum over k of X(a,k)·conj(X(b,k)), with each part then arithmetically shifted right by the latched shift. The real part is Xa.re·Xb.re + Xa.im·Xb.im and the imaginary part is Xa.im·Xb.re − Xa.re·Xb.im. This holds for sample values in −32767..32767.
- R2: For a < b, the entry read at (a,b) has the same real part as the stored entry (b,a) and the negated imaginary part.
- R3: Sample n of the stream is row n/K and snapshot n%K. It goes to bank (n%K)%16 at address ((n%K)/16)·A + n/K. Results are correct for K above 16 and for K not a multiple of 16.
- R4: Exactly A(A+1)/2 entries are computed. `done` goes high for one cycle only, and it is first visible A(A+1)/2·K cycles after the clock edge that accepts the last sample.
- R5: Results are written in column order: top to bottom within a column, and the columns from left to right.
- R6: `norm_shift` (0..8) is latched on `start` and applied as an arithmetic right shift to the real and imaginary parts of each stored entry.
- R7: After reset, `done` is low and every entry reads as zero.
- R8: A write request (`wr_en`) outside the sample-loading phase, including during computation, has no effect on the results.
- R9: Channel counts from 1 to 8 and snapshot counts from 1 to 256 are handled, including A=1, K=1 and A=8, K=256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new estimate when idle |
| num_rows | input | 4 | Channel count A, 1..8 |
| num_snap | input | 9 | Snapshot count K, 1..256 |
| norm_shift | input | 4 | Right shift applied to results |
| wr_en | input | 1 | Sample write strobe |
| wr_re | input | 16 | Sample real part, signed |
| wr_im | input | 16 | Sample imaginary part, signed |
| rd_row | input | 3 | Result row index |
| rd_col | input | 3 | Result column index |
| rd_re | output | 40 | Result real part, signed, combinational |
| rd_im | output | 40 | Result imaginary part, signed, combinational |
| done | output | 1 | One-cycle pulse after the last entry is stored |

## Verification
Each loaded sample is captured on the edge that follows its drive. The latency count starts at the edge that captures the last sample, and the bench expects `done` on the falling edge A(A+1)/2·K cycles later, then expects it low again one cycle after that. The result port is combinational, so every entry is read a short delay after its indices change while the block is idle. The entries are compared with sums the bench forms itself, in which the shift is applied before the conjugation. Stray writes are driven during the whole computation phase, and the results that follow are compared as usual.

// File: rtl/covar_pkg.sv
package covar_pkg;
    localparam int IQ_W   = 16;
    localparam int ACC_W  = 40;
    localparam int PROD_W = 2 * IQ_W + 1;

    typedef struct packed {
        logic signed [IQ_W-1:0] re;
        logic signed [IQ_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } acc_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC} state_t;

    // x * conj(y), widened to accumulator precision
    function automatic acc_t mul_conj(cplx_t x, cplx_t y);
        acc_t r;
        logic signed [PROD_W-1:0] xr, xi, yr, yi, pr, pi;
        xr = PROD_W'(x.re);
        xi = PROD_W'(x.im);
        yr = PROD_W'(y.re);
        yi = PROD_W'(y.im);
        pr = xr * yr + xi * yi;
        pi = xi * yr - xr * yi;
        r.re = ACC_W'(pr);
        r.im = ACC_W'(pi);
        return r;
    endfunction

    function automatic acc_t conj_acc(acc_t v);
        acc_t r;
        r.re = v.re;
        r.im = -v.im;
        return r;
    endfunction

    // Position of lower-triangle entry (row >= col) in column-order storage
    function automatic int tri_index(int row, int col, int rows);
        return col * rows - (col * (col - 1)) / 2 + (row - col);
    endfunction
endpackage

// File: rtl/covar_sample_store.sv
module covar_sample_store
    import covar_pkg::*;
#(
    parameter int MAX_ROWS  = 8,
    parameter int MAX_SNAP  = 256,
    parameter int NUM_BANKS = 16,
    localparam int ROW_W  = $clog2(MAX_ROWS),
    localparam int ROWS_W = $clog2(MAX_ROWS + 1),
    localparam int COL_W  = $clog2(MAX_SNAP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROWS_W-1:0] rows,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  cplx_t             wr_data,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [ROW_W-1:0]  rd_row_a,
    input  logic [ROW_W-1:0]  rd_row_b,
    output cplx_t             rd_a,
    output cplx_t             rd_b
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int DEPTH  = (MAX_SNAP / NUM_BANKS) * MAX_ROWS;
    localparam int ADDR_W = $clog2(DEPTH);

    function automatic logic [ADDR_W-1:0] addr_of(logic [COL_W-1:0] col,
                                                  logic [ROW_W-1:0] row,
                                                  logic [ROWS_W-1:0] nrows);
        return ADDR_W'(col[COL_W-1:BANK_W]) * ADDR_W'(nrows) + ADDR_W'(row);
    endfunction

    logic [BANK_W-1:0] wr_bank, rd_bank;
    logic [ADDR_W-1:0] wr_addr, addr_a, addr_b;
    cplx_t             bank_a [NUM_BANKS];
    cplx_t             bank_b [NUM_BANKS];

    assign wr_bank = wr_col[BANK_W-1:0];
    assign rd_bank = rd_col[BANK_W-1:0];
    assign wr_addr = addr_of(wr_col, wr_row, rows);
    assign addr_a  = addr_of(rd_col, rd_row_a, rows);
    assign addr_b  = addr_of(rd_col, rd_row_b, rows);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        cplx_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == BANK_W'(g)) mem[wr_addr] <= wr_data;
        end
        assign bank_a[g] = mem[addr_a];
        assign bank_b[g] = mem[addr_b];
    end

    assign rd_a = bank_a[rd_bank];
    assign rd_b = bank_b[rd_bank];

    // R3: consecutive snapshots of one row land in consecutive banks
    p_bank_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && wr_row == $past(wr_row) &&
         wr_col == $past(wr_col) + COL_W'(1))
        |-> wr_bank == $past(wr_bank) + BANK_W'(1));
endmodule

// File: rtl/covar_mac.sv
module covar_mac
    import covar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  first,
    input  cplx_t x_a,
    input  cplx_t x_b,
    output acc_t  sum
);
    acc_t acc_q;
    acc_t prod;

    always_comb begin
        prod   = mul_conj(x_a, x_b);
        sum.re = (first ? '0 : acc_q.re) + prod.re;
        sum.im = (first ? '0 : acc_q.im) + prod.im;
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= sum;
    end
endmodule

// File: rtl/covar_result_store.sv
module covar_result_store
    import covar_pkg::*;
#(
    parameter int MAX_ROWS = 8,
    localparam int ROW_W     = $clog2(MAX_ROWS),
    localparam int ROWS_W    = $clog2(MAX_ROWS + 1),
    localparam int RES_DEPTH = MAX_ROWS * (MAX_ROWS + 1) / 2,
    localparam int RES_W     = $clog2(RES_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROWS_W-1:0] rows,
    input  logic              we,
    input  logic [RES_W-1:0]  widx,
    input  acc_t              wdata,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [ROW_W-1:0]  rd_col,
    output acc_t              rd_data
);
    acc_t mem [RES_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RES_DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        int   idx;
        logic upper;
        upper = rd_row < rd_col;
        if (upper) idx = tri_index(int'(rd_col), int'(rd_row), int'(rows));
        else       idx = tri_index(int'(rd_row), int'(rd_col), int'(rows));
        if (idx < 0 || idx >= RES_DEPTH) rd_data = '0;
        else if (upper)                  rd_data = conj_acc(mem[idx]);
        else                             rd_data = mem[idx];
    end
endmodule

// File: rtl/covar_est.sv
module covar_est
    import covar_pkg::*;
#(
    parameter int MAX_ROWS  = 8,
    parameter int MAX_SNAP  = 256,
    parameter int NUM_BANKS = 16,
    localparam int ROW_W   = $clog2(MAX_ROWS),
    localparam int ROWS_W  = $clog2(MAX_ROWS + 1),
    localparam int COL_W   = $clog2(MAX_SNAP),
    localparam int SNAPS_W = $clog2(MAX_SNAP + 1),
    localparam int SH_W    = $clog2(COL_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ROWS_W-1:0]       num_rows,
    input  logic [SNAPS_W-1:0]      num_snap,
    input  logic [SH_W-1:0]         norm_shift,
    input  logic                    wr_en,
    input  logic signed [IQ_W-1:0]  wr_re,
    input  logic signed [IQ_W-1:0]  wr_im,
    input  logic [ROW_W-1:0]        rd_row,
    input  logic [ROW_W-1:0]        rd_col,
    output logic signed [ACC_W-1:0] rd_re,
    output logic signed [ACC_W-1:0] rd_im,
    output logic                    done
);
    localparam int RES_DEPTH = MAX_ROWS * (MAX_ROWS + 1) / 2;
    localparam int RES_W     = $clog2(RES_DEPTH);

    state_t            state;
    logic [ROWS_W-1:0] rows_q;
    logic [ROW_W-1:0]  last_row, ld_row, ca, cb;
    logic [COL_W-1:0]  last_col, ld_col, ck;
    logic [SH_W-1:0]   shift_q;
    logic [RES_W-1:0]  eidx;
    logic              done_q;

    logic  st_we, res_we;
    cplx_t wr_data, x_a, x_b;
    acc_t  sum, scaled, rd_data;

    assign st_we   = wr_en && state == ST_LOAD;
    assign res_we  = state == ST_CALC && ck == last_col;
    assign wr_data = '{re: wr_re, im: wr_im};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done_q   <= 1'b0;
            rows_q   <= '0;
            last_row <= '0;
            last_col <= '0;
            shift_q  <= '0;
            ld_row   <= '0;
            ld_col   <= '0;
            ca       <= '0;
            cb       <= '0;
            ck       <= '0;
            eidx     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    rows_q   <= num_rows;
                    last_row <= ROW_W'(num_rows - ROWS_W'(1));
                    last_col <= COL_W'(num_snap - SNAPS_W'(1));
                    shift_q  <= norm_shift;
                    ld_row   <= '0;
                    ld_col   <= '0;
                    state    <= ST_LOAD;
                end
                ST_LOAD: if (wr_en) begin
                    if (ld_col == last_col) begin
                        ld_col <= '0;
                        if (ld_row == last_row) begin
                            state <= ST_CALC;
                            ca    <= '0;
                            cb    <= '0;
                            ck    <= '0;
                            eidx  <= '0;
                        end else begin
                            ld_row <= ld_row + ROW_W'(1);
                        end
                    end else begin
                        ld_col <= ld_col + COL_W'(1);
                    end
                end
                ST_CALC: begin
                    if (ck == last_col) begin
                        ck <= '0;
                        if (ca == last_row) begin
                            if (cb == last_row) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                cb   <= cb + ROW_W'(1);
                                ca   <= cb + ROW_W'(1);
                                eidx <= eidx + RES_W'(1);
                            end
                        end else begin
                            ca   <= ca + ROW_W'(1);
                            eidx <= eidx + RES_W'(1);
                        end
                    end else begin
                        ck <= ck + COL_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    covar_sample_store #(
        .MAX_ROWS (MAX_ROWS),
        .MAX_SNAP (MAX_SNAP),
        .NUM_BANKS(NUM_BANKS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rows    (rows_q),
        .wr_en   (st_we),
        .wr_row  (ld_row),
        .wr_col  (ld_col),
        .wr_data (wr_data),
        .rd_col  (ck),
        .rd_row_a(ca),
        .rd_row_b(cb),
        .rd_a    (x_a),
        .rd_b    (x_b)
    );

    covar_mac u_mac (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_CALC),
        .first(ck == '0),
        .x_a  (x_a),
        .x_b  (x_b),
        .sum  (sum)
    );

    always_comb begin
        scaled.re = $signed(sum.re) >>> shift_q;
        scaled.im = $signed(sum.im) >>> shift_q;
    end

    covar_result_store #(.MAX_ROWS(MAX_ROWS)) u_res (
        .clk    (clk),
        .rst    (rst),
        .rows   (rows_q),
        .we     (res_we),
        .widx   (eidx),
        .wdata  (scaled),
        .rd_row (rd_row),
        .rd_col (rd_col),
        .rd_data(rd_data)
    );

    assign rd_re = rd_data.re;
    assign rd_im = rd_data.im;
    assign done  = done_q;

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: completion follows directly on the final result write
    p_done_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(res_we));

    // R5: write counter walks the lower triangle in column order
    p_res_order_r5: assert property (@(posedge clk) disable iff (rst)
        res_we |-> int'(eidx) == tri_index(int'(ca), int'(cb), int'(rows_q)));
endmodule

// File: tb/covar_est_tb_top.sv
module covar_est_tb_top;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [3:0]         num_rows = 4'd1;
    logic [8:0]         num_snap = 9'd1;
    logic [3:0]         norm_shift = 4'd0;
    logic               wr_en = 1'b0;
    logic signed [15:0] wr_re = '0;
    logic signed [15:0] wr_im = '0;
    logic [2:0]         rd_row = '0;
    logic [2:0]         rd_col = '0;
    logic signed [39:0] rd_re, rd_im;
    logic               done;

    covar_est dut_i (
        .clk(clk), .rst(rst), .start(start), .num_rows(num_rows),
        .num_snap(num_snap), .norm_shift(norm_shift), .wr_en(wr_en),
        .wr_re(wr_re), .wr_im(wr_im), .rd_row(rd_row), .rd_col(rd_col),
        .rd_re(rd_re), .rd_im(rd_im), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int s_re [8][256];
    int s_im [8][256];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd_sample();
        return int'($urandom % 32'd65535) - 32767;
    endfunction

    // Lower-triangle sum for a >= b, shifted, as 40-bit values
    function automatic longint lower_part(int a, int b, int k_n, int sh, bit im_part);
        longint sr = 0;
        longint si = 0;
        logic signed [39:0] v;
        for (int k = 0; k < k_n; k++) begin
            sr += longint'(s_re[a][k]) * s_re[b][k] + longint'(s_im[a][k]) * s_im[b][k];
            si += longint'(s_im[a][k]) * s_re[b][k] - longint'(s_re[a][k]) * s_im[b][k];
        end
        v = im_part ? 40'(si) : 40'(sr);
        v = v >>> sh;
        return longint'(v);
    endfunction

    task automatic run_case(int a_n, int k_n, int sh, int pat, bit stray);
        int cnt;
        for (int r = 0; r < a_n; r++) begin
            for (int k = 0; k < k_n; k++) begin
                case (pat)
                    0: begin s_re[r][k] = rnd_sample(); s_im[r][k] = rnd_sample(); end
                    1: begin
                        s_re[r][k] = ((r * 3 + k) % 2 == 0) ? 32767 : -32767;
                        s_im[r][k] = ((r + k * 5) % 3 == 0) ? -32767 : 32767;
                    end
                    default: begin s_re[r][k] = r * 7 - k + 3; s_im[r][k] = k * 2 - r; end
                endcase
            end
        end
        @(negedge clk);
        start      = 1'b1;
        num_rows   = 4'(a_n);
        num_snap   = 9'(k_n);
        norm_shift = 4'(sh);
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < a_n; r++) begin
            for (int k = 0; k < k_n; k++) begin
                wr_en = 1'b1;
                wr_re = 16'(s_re[r][k]);
                wr_im = 16'(s_im[r][k]);
                @(negedge clk);
            end
        end
        wr_en = 1'b0;
        cnt   = 0;
        while (!done && cnt < 20000) begin
            if (stray) begin
                // R8: writes during computation must be ignored
                wr_en = 1'b1;
                wr_re = 16'(rnd_sample());
                wr_im = 16'(rnd_sample());
            end
            @(negedge clk);
            cnt++;
        end
        wr_en = 1'b0;
        // R4: latency from last accepted sample to done
        check(cnt == a_n * (a_n + 1) / 2 * k_n, "R4", "done latency",
              longint'(cnt), longint'(a_n * (a_n + 1) / 2 * k_n));
        @(negedge clk);
        check(done == 1'b0, "R4", "done single pulse", longint'(done), 0);
        // R1 lower entries, R2 upper entries, R3/R5 placement, R6 shift
        for (int a = 0; a < a_n; a++) begin
            for (int b = 0; b < a_n; b++) begin
                longint er, ei;
                rd_row = 3'(a);
                rd_col = 3'(b);
                #1;
                if (a >= b) begin
                    er = lower_part(a, b, k_n, sh, 1'b0);
                    ei = lower_part(a, b, k_n, sh, 1'b1);
                    check(longint'(rd_re) == er, stray ? "R1/R8" : "R1", "lower re", longint'(rd_re), er);
                    check(longint'(rd_im) == ei, stray ? "R1/R8" : "R1", "lower im", longint'(rd_im), ei);
                end else begin
                    er = lower_part(b, a, k_n, sh, 1'b0);
                    ei = -lower_part(b, a, k_n, sh, 1'b1);
                    check(longint'(rd_re) == er, "R2", "upper re", longint'(rd_re), er);
                    check(longint'(rd_im) == ei, "R2", "upper im", longint'(rd_im), ei);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(done == 1'b0, "R7", "done after reset", longint'(done), 0);
        rd_row = 3'd0; rd_col = 3'd0; #1;
        check(rd_re == '0 && rd_im == '0, "R7", "entry 0,0 after reset", longint'(rd_re), 0);
        rd_row = 3'd2; rd_col = 3'd5; #1;
        check(rd_re == '0 && rd_im == '0, "R7", "entry 2,5 after reset", longint'(rd_re), 0);

        run_case(3, 5, 0, 0, 1'b0);     // R1 R2 R5 small random
        run_case(5, 37, 3, 0, 1'b1);    // R3 K>16 not multiple, R6 shift, R8 stray
        run_case(8, 256, 8, 1, 1'b0);   // R9 maximum size, R6 divide by K
        run_case(1, 1, 0, 2, 1'b0);     // R9 minimum size
        run_case(4, 16, 0, 2, 1'b1);    // R3 exact bank count, R8 stray
        run_case(6, 23, 1, 0, 1'b0);    // R1 R6 random

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule